// File: doc/BRIEF.md
# Address Update Unit with Linear, Circular and Bit-Reversed Arithmetic

This block computes data memory addresses for a signal-processing datapath. It keeps a small file of pointer sets. Each set holds three registers: an address, a signed offset and a modifier. Every cycle the caller names one set and a step kind. The block then presents two values. The first is the address as it stands, used as the effective address. The second is the updated address. When the update is enabled, that updated address is written back at the next clock edge.

Three sums are formed side by side:
- a plain two's-complement sum of the address and the step;
- a circular-buffer sum that folds the plain result back inside a buffer of length M;
- a reverse-carry sum whose carry runs from the most significant bit down to the least significant bit, which walks bit-reversed (FFT) address orders.

The modifier register of the selected set decides which of the three sums becomes the new address. A separate write port loads any register of any set.

Top module: `addr_gen_alu`

## Requirements
- R1: After reset every address and offset register is 0 and every modifier register is all-ones, so arithmetic is linear.
- R2: When `wr_en` is high, `wr_data` is stored at the clock edge into set `wr_idx`. The register is chosen by `wr_sel`: 0 selects the address, 1 the offset and 2 the modifier. `wr_sel` = 3 changes nothing.
- R3: `ea_out` is the current, pre-update address of set `upd_idx`. `next_addr` is, combinationally, the value that an update would store.
- R4: The step is chosen by `upd_op`: 0 gives a step of 0 (hold), 1 gives +1, 2 gives −1 and 3 gives the set's offset taken as a signed 24-bit value.
- R5: A modifier of all-ones selects linear arithmetic: address plus step, modulo 2^24.
- R6: A modifier m with 1 ≤ m ≤ 2^15−1 selects circular arithmetic with length M = m+1. The buffer base is the address with its low k bits cleared, where 2^k is the smallest power of two that is at least M. A result past base+M−1 wraps to the base side, and a result below the base wraps to the top side.
- R7: In circular mode, a step whose magnitude exceeds M falls back to the linear result.
- R8: A modifier of 0 selects reverse-carry arithmetic. The result equals bitrev(bitrev(address) + bitrev(step)) over 24 bits.
- R9: Any other modifier value (at least 2^15, but not all-ones) selects linear arithmetic.
- R10: With `upd_en` high, only the address register of set `upd_idx` takes `next_addr` at the clock edge. All other address registers keep their value.
- R11: If, in the same cycle, the write port targets the address register of the set being updated, the written data wins. A write to a different set happens together with the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Write the updated address back at this edge |
| upd_idx | input | 2 | Set used for address generation |
| upd_op | input | 2 | Step kind: hold, +1, −1, +offset |
| wr_en | input | 1 | Register load strobe |
| wr_idx | input | 2 | Set targeted by the load |
| wr_sel | input | 2 | Register targeted: address, offset, modifier, none |
| wr_data | input | 24 | Load value |
| ea_out | output | 24 | Effective (pre-update) address |
| next_addr | output | 24 | Updated address |

## Verification
The bench targets four kinds of corner case:
- **Circular wrap in both directions at the exact buffer edges**, including a step equal to M and the largest supported length. A design with a wrong correction would leave the buffer or land one slot off.
- **Steps just larger than M.** A design that misses the fallback would fold these back into the buffer instead of stepping linearly.
- **The reverse-carry sequence and the carry out of the top bit.** A forward carry would produce ordinary increments there.
- **Same-cycle collisions between the load port and an update, and the ignored select code.** A wrong priority or a wrong select decode would corrupt the address that is read out next.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {STEP_HOLD, STEP_INC, STEP_DEC, STEP_OFS} step_e;
  typedef enum logic [1:0] {SEL_ADDR, SEL_OFS, SEL_MOD, SEL_NONE} wsel_e;
  typedef enum logic [1:0] {AR_LINEAR, AR_MODULO, AR_REVERSE, AR_RSVD} arith_e;
endpackage

// File: rtl/agu_regfile.sv
module agu_regfile import agu_pkg::*; #(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  localparam int IW   = $clog2(NTRIP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  wsel_e             wr_sel,
  input  logic [IW-1:0]     wr_idx,
  input  logic [AW-1:0]     wr_data,
  input  logic              upd_en,
  input  logic [IW-1:0]     upd_idx,
  input  logic [AW-1:0]     upd_val,
  output logic [AW-1:0]     rd_addr,
  output logic [AW-1:0]     rd_ofs,
  output logic [AW-1:0]     rd_mod,
  output logic [NTRIP*AW-1:0] addr_all
);
  logic [AW-1:0] addr_q [NTRIP];
  logic [AW-1:0] ofs_q  [NTRIP];
  logic [AW-1:0] mod_q  [NTRIP];

  for (genvar t = 0; t < NTRIP; t++) begin : g_set
    logic hit_wr;
    logic hit_upd;
    assign hit_wr  = wr_en && (wr_idx == IW'(t));
    assign hit_upd = upd_en && (upd_idx == IW'(t));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        addr_q[t] <= '0;
        ofs_q[t]  <= '0;
        mod_q[t]  <= '1;
      end else begin
        if (hit_wr && wr_sel == SEL_ADDR) addr_q[t] <= wr_data;
        else if (hit_upd)                 addr_q[t] <= upd_val;
        if (hit_wr && wr_sel == SEL_OFS)  ofs_q[t]  <= wr_data;
        if (hit_wr && wr_sel == SEL_MOD)  mod_q[t]  <= wr_data;
      end
    end

    assign addr_all[t*AW +: AW] = addr_q[t];
  end

  assign rd_addr = addr_q[upd_idx];
  assign rd_ofs  = ofs_q[upd_idx];
  assign rd_mod  = mod_q[upd_idx];
endmodule

// File: rtl/agu_arith.sv
module agu_arith import agu_pkg::*; #(
  parameter int AW   = 24,
  parameter int MODW = 15
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ofs,
  input  logic [AW-1:0] modv,
  input  step_e         op,
  output logic [AW-1:0] next_val,
  output arith_e        mode,
  output logic          step_err,
  output logic [AW-1:0] blk_mask
);
  localparam int SW = AW + 2;

  function automatic logic [AW-1:0] bitrev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  // fill every bit below the leading one: size-minus-one of the enclosing power of two
  function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int k = 1; k < AW; k = k * 2) r = r | (r >> k);
    return r;
  endfunction

  function automatic logic [AW-1:0] circ_sum(input logic [AW-1:0] a,
                                             input logic [AW-1:0] st,
                                             input logic [AW-1:0] m,
                                             input logic [AW-1:0] msk);
    logic [SW-1:0] rel, stp, len, s;
    rel = {2'b00, a & msk};
    stp = {{2{st[AW-1]}}, st};
    len = {2'b00, m} + SW'(1);
    s   = rel + stp;
    if (s[SW-1])      s = s + len;
    else if (s >= len) s = s - len;
    return (a & ~msk) | s[AW-1:0];
  endfunction

  function automatic logic too_big(input logic [AW-1:0] st, input logic [AW-1:0] m);
    logic [AW:0] mag;
    mag = st[AW-1] ? {1'b0, -st} : {1'b0, st};
    return mag > ({1'b0, m} + (AW+1)'(1));
  endfunction

  logic [AW-1:0] step;
  logic [AW-1:0] lin_sum, mod_sum, rev_sum;

  always_comb begin
    unique case (op)
      STEP_HOLD: step = '0;
      STEP_INC:  step = AW'(1);
      STEP_DEC:  step = '1;
      default:   step = ofs;
    endcase
  end

  always_comb begin
    if (&modv)                     mode = AR_LINEAR;
    else if (modv == '0)           mode = AR_REVERSE;
    else if ((modv >> MODW) == '0) mode = AR_MODULO;
    else                           mode = AR_LINEAR;
  end

  // the three sums are formed in parallel; the decoded mode picks one
  assign blk_mask = smear(modv);
  assign lin_sum  = addr + step;
  assign mod_sum  = circ_sum(addr, step, modv, blk_mask);
  assign rev_sum  = bitrev(bitrev(addr) + bitrev(step));
  assign step_err = too_big(step, modv);

  always_comb begin
    unique case (mode)
      AR_REVERSE: next_val = rev_sum;
      AR_MODULO:  next_val = step_err ? lin_sum : mod_sum;
      default:    next_val = lin_sum;
    endcase
  end
endmodule

// File: rtl/addr_gen_alu.sv
module addr_gen_alu import agu_pkg::*; #(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  parameter int MODW  = 15,
  localparam int IW   = $clog2(NTRIP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [1:0]    upd_op,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_sel,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] ea_out,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0]       cur_addr, cur_ofs, cur_mod;
  logic [NTRIP*AW-1:0] addr_all;
  arith_e              arith_mode;
  logic                step_err;
  logic [AW-1:0]       blk_mask;

  agu_regfile #(.AW(AW), .NTRIP(NTRIP)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_sel(wsel_e'(wr_sel)), .wr_idx(wr_idx), .wr_data(wr_data),
    .upd_en(upd_en), .upd_idx(upd_idx), .upd_val(next_addr),
    .rd_addr(cur_addr), .rd_ofs(cur_ofs), .rd_mod(cur_mod),
    .addr_all(addr_all)
  );

  agu_arith #(.AW(AW), .MODW(MODW)) u_ar (
    .addr(cur_addr), .ofs(cur_ofs), .modv(cur_mod), .op(step_e'(upd_op)),
    .next_val(next_addr), .mode(arith_mode), .step_err(step_err), .blk_mask(blk_mask)
  );

  assign ea_out = cur_addr;
endmodule

// File: rtl/agu_alu_checker.sv
module agu_alu_checker #(
  parameter int AW    = 24,
  parameter int NTRIP = 4,
  localparam int IW   = $clog2(NTRIP)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                upd_en,
  input logic [IW-1:0]       upd_idx,
  input logic [1:0]          upd_op,
  input logic                wr_en,
  input logic [IW-1:0]       wr_idx,
  input logic [1:0]          wr_sel,
  input logic [AW-1:0]       wr_data,
  input logic [AW-1:0]       ea_out,
  input logic [AW-1:0]       next_addr,
  input logic [NTRIP*AW-1:0] addr_all,
  input logic [1:0]          mode,
  input logic                step_err,
  input logic [AW-1:0]       blk_mask
);
  logic [AW-1:0] arr [NTRIP];
  for (genvar t = 0; t < NTRIP; t++) begin : g_arr
    assign arr[t] = addr_all[t*AW +: AW];

    // R10: sets neither updated nor loaded keep their address
    a_r10_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(upd_en && upd_idx == IW'(t)) && !(wr_en && wr_sel == 2'd0 && wr_idx == IW'(t))
      |=> $stable(arr[t]));
  end

  a_r10_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && !(wr_en && wr_sel == 2'd0 && wr_idx == upd_idx)
    |=> arr[$past(upd_idx)] == $past(next_addr));

  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd0 |=> arr[$past(wr_idx)] == $past(wr_data));

  a_r6_stays_in_block: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd1 && !step_err |-> (next_addr & ~blk_mask) == (ea_out & ~blk_mask));

  a_r5_linear_inc: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd0 && upd_op == 2'd1 |-> next_addr == ea_out + AW'(1));
endmodule

bind addr_gen_alu agu_alu_checker #(.AW(AW), .NTRIP(NTRIP)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_idx(upd_idx), .upd_op(upd_op),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
  .ea_out(ea_out), .next_addr(next_addr), .addr_all(addr_all),
  .mode(arith_mode), .step_err(step_err), .blk_mask(blk_mask)
);

// File: tb/test_addr_gen_alu.sv
`timescale 1ns/1ps
module test_addr_gen_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [1:0]  upd_idx = '0;
  logic [1:0]  upd_op = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [1:0]  wr_sel = '0;
  logic [23:0] wr_data = '0;
  logic [23:0] ea_out, next_addr;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_gen_alu i_addr_gen_alu (.*);

  typedef struct packed {
    logic [23:0] md; logic [23:0] ad; logic [23:0] of;
    logic [1:0] op; logic [23:0] ex; logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{24'hFFFFFF, 24'h000010, 24'h0,      2'd1, 24'h000011, 4'd5}, // R5 plain +1
    '{24'hFFFFFF, 24'hFFFFFF, 24'h0,      2'd1, 24'h000000, 4'd5}, // R5 wrap at top
    '{24'hFFFFFF, 24'h000000, 24'h0,      2'd2, 24'hFFFFFF, 4'd5}, // R5 wrap at zero
    '{24'hFFFFFF, 24'h000100, 24'hFFFFF0, 2'd3, 24'h0000F0, 4'd4}, // R4 negative offset
    '{24'hFFFFFF, 24'h000123, 24'h0,      2'd0, 24'h000123, 4'd4}, // R4 hold
    '{24'h000009, 24'h000105, 24'h0,      2'd1, 24'h000106, 4'd6}, // R6 inside buffer
    '{24'h000009, 24'h000109, 24'h0,      2'd1, 24'h000100, 4'd6}, // R6 wrap up
    '{24'h000009, 24'h000100, 24'h0,      2'd2, 24'h000109, 4'd6}, // R6 wrap down
    '{24'h000009, 24'h000105, 24'h000007, 2'd3, 24'h000102, 4'd6}, // R6 offset wrap up
    '{24'h000009, 24'h000102, 24'hFFFFF9, 2'd3, 24'h000105, 4'd6}, // R6 offset wrap down
    '{24'h000009, 24'h000105, 24'h00000A, 2'd3, 24'h000105, 4'd6}, // R6 step equal to M
    '{24'h000009, 24'h000105, 24'h00000B, 2'd3, 24'h000110, 4'd7}, // R7 step M+1
    '{24'h000009, 24'h000105, 24'hFFFFF5, 2'd3, 24'h0000FA, 4'd7}, // R7 step -(M+1)
    '{24'h000007, 24'h000237, 24'h0,      2'd1, 24'h000230, 4'd6}, // R6 power-of-two length
    '{24'h007FFF, 24'h017FFF, 24'h0,      2'd1, 24'h010000, 4'd6}, // R6 largest length
    '{24'h008000, 24'h000109, 24'h0,      2'd1, 24'h00010A, 4'd9}, // R9 out of range
    '{24'h000000, 24'h000000, 24'h800000, 2'd3, 24'h800000, 4'd8}, // R8 bit-reversed walk
    '{24'h000000, 24'h800000, 24'h800000, 2'd3, 24'h400000, 4'd8}, // R8
    '{24'h000000, 24'h400000, 24'h800000, 2'd3, 24'hC00000, 4'd8}, // R8
    '{24'h000000, 24'h000001, 24'h0,      2'd1, 24'h000000, 4'd8}, // R8 carry out of bit 0
    '{24'h000000, 24'h000000, 24'h0,      2'd2, 24'hFFFFFF, 4'd8}  // R8 minus one
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] idx, input logic [1:0] sel, input logic [23:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] idx, input logic [1:0] op);
    upd_idx = idx; upd_op = op; #1;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;

    // R1 reset state
    for (int t = 0; t < 4; t++) begin
      look(2'(t), 2'd3); check("R1 address", ea_out, 24'h0);
      check("R1 offset", next_addr, 24'h0);
      look(2'(t), 2'd1); check("R1 linear", next_addr, 24'h000001);
    end
    load(2'd0, 2'd0, 24'h00FFFF);
    look(2'd0, 2'd1); check("R1 modifier linear", next_addr, 24'h010000);

    // R2 load select 3 is ignored
    load(2'd1, 2'd0, 24'h000055);
    load(2'd1, 2'd3, 24'h000ABC);
    look(2'd1, 2'd3); check("R2 sel3 address", ea_out, 24'h000055);
    check("R2 sel3 offset", next_addr, 24'h000055);
    look(2'd1, 2'd1); check("R2 sel3 modifier", next_addr, 24'h000056);

    // R10 update touches only its own set
    load(2'd2, 2'd0, 24'h000200);
    load(2'd3, 2'd0, 24'h000300);
    look(2'd2, 2'd1); upd_en = 1'b1; tick(); upd_en = 1'b0;
    look(2'd2, 2'd0); check("R10 updated", ea_out, 24'h000201);
    look(2'd1, 2'd0); check("R10 other", ea_out, 24'h000055);
    look(2'd3, 2'd0); check("R10 other", ea_out, 24'h000300);

    // R11 same-cycle collisions
    look(2'd2, 2'd1); upd_en = 1'b1;
    load(2'd2, 2'd0, 24'h000777); upd_en = 1'b0;
    look(2'd2, 2'd0); check("R11 load wins", ea_out, 24'h000777);
    look(2'd2, 2'd1); upd_en = 1'b1;
    load(2'd3, 2'd0, 24'h000333); upd_en = 1'b0;
    look(2'd2, 2'd0); check("R11 update beside load", ea_out, 24'h000778);
    look(2'd3, 2'd0); check("R11 load beside update", ea_out, 24'h000333);

    // table of arithmetic vectors
    for (int i = 0; i < NV; i++) begin
      logic [1:0] t;
      string tag;
      t = 2'(i % 4);
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      load(t, 2'd2, VEC[i].md);
      load(t, 2'd1, VEC[i].of);
      load(t, 2'd0, VEC[i].ad);
      look(t, VEC[i].op);
      check({"R3 ea ", tag}, ea_out, VEC[i].ad);
      check(tag, next_addr, VEC[i].ex);
      upd_en = 1'b1; tick(); upd_en = 1'b0;
      look(t, 2'd0);
      check({"R10 stored ", tag}, ea_out, VEC[i].ex);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule